// File: doc/BRIEF.md
# Sterilisation Lamp Controller with Door Interlock

This block runs the lamp in a sterilisation chamber from two momentary pushbuttons, one to light the lamp and one to put it out. A panel-enable input decides whether those buttons count. The lamp state is a set/clear storage bit that only the buttons can change, and only while the panel is enabled. When the panel is disabled, the lamp holds whatever state it had.

A second output releases the chamber door. It does so only when three things are true together: the lamp is off, the panel is disabled, and the optional lamp-current sense input reads no current.

Every asynchronous input is brought into the clock domain inside the block. The buttons and the panel enable then pass through a debouncer whose stable time is a parameter. The relay stages and the solenoid drive sit outside the block. They take `lamp_drive` and `door_release` as plain logic levels.

Top module: `lamp_lockout_ctrl`

## Requirements
- R1: With the filtered panel enable high and the light button (filtered) pressed while the off button is not, `lamp_drive` goes to 1.
- R2: With the filtered panel enable low, neither button changes `lamp_drive`, which keeps its last value.
- R3: `door_release` is 1 exactly when `lamp_drive` is 0, the filtered panel enable is 0, and (when sensing is fitted) the synchronised sense input is 0; otherwise it is 0.
- R4: With neither button pressed, `lamp_drive` keeps its value for any number of cycles.
- R5: With both buttons pressed and the panel enabled, the off button takes priority and `lamp_drive` goes to 0.
- R6: A synchronous active-high `rst` clears the lamp state, every synchroniser and every debouncer. During and after reset, `lamp_drive` is 0 and `door_release` is 1 while all inputs are 0.
- R7: Each button and the panel enable pass through a SYNC_STAGES-flop synchroniser and then a debouncer. The debouncer accepts a new level only after it has been sampled unchanged for STABLE_CYCLES consecutive clocks, so shorter pulses are discarded. A clean level change at the pin reaches `lamp_drive` on the STABLE_CYCLES+3rd rising edge, counting the edge that first samples it.
- R8: When HAS_SENSE is 1, `lamp_sense` passes through a SYNC_STAGES-flop synchroniser and no debouncer, and a high sense holds `door_release` at 0. When HAS_SENSE is 0, `lamp_sense` has no effect.
- R9: `door_release` is a direct combination of registered state, so it falls in the same cycle in which the lamp state, the filtered enable or the synchronised sense becomes unsafe. It is never 1 while `lamp_drive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_btn | input | 1 | Light-lamp pushbutton, active high, asynchronous |
| off_btn | input | 1 | Extinguish-lamp pushbutton, active high, asynchronous |
| panel_enable | input | 1 | High lets the buttons act; low locks them out and allows door release |
| lamp_sense | input | 1 | Lamp current sense, high while current flows, asynchronous |
| lamp_drive | output | 1 | Lamp on request to the interposing stage |
| door_release | output | 1 | Door unlock request |

## Verification
The bench builds the controller with STABLE_CYCLES set to 3, SYNC_STAGES set to 2 and HAS_SENSE set to 1. The short stable time makes debounce acceptance and rejection visible within a few clocks, so glitches of two cycles and bursts of pseudo-random bouncing can be compared cycle by cycle against a queue-based model. Fitting the sense input brings the shorted-switch case of the interlock within reach. It also exercises the synchroniser-only path, which has a different latency from the debounced path.

// File: rtl/lamp_ctrl_pkg.sv
package lamp_ctrl_pkg;

   // Order of the debounced control inputs inside the filter bank
   typedef enum int unsigned {
      CH_LIGHT  = 0,
      CH_DOUSE  = 1,
      CH_PANEL  = 2
   } ctrl_chan_e;

   localparam int unsigned NUM_CTRL_CH = 3;

   typedef struct packed {
      logic panel;
      logic douse;
      logic light;
   } ctrl_levels_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/lc_input_filter.sv
module lc_input_filter
   import lamp_ctrl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned STABLE_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_in,
   output logic clean_out
);

   localparam int unsigned CW = cnt_width(STABLE_CYCLES);
   localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lc_input_filter: SYNC_STAGES must be at least 2");
      end
      if (STABLE_CYCLES < 1) begin : g_bad_stable
         $error("lc_input_filter: STABLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_sh;
   logic                   sync_lvl;
   logic [CW-1:0]          run_cnt;
   logic                   held_lvl;

   always_ff @(posedge clk) begin
      if (rst) sync_sh <= '0;
      else     sync_sh <= {sync_sh[SYNC_STAGES-2:0], raw_in};
   end

   assign sync_lvl = sync_sh[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt  <= '0;
         held_lvl <= 1'b0;
      end else if (sync_lvl == held_lvl) begin
         run_cnt <= '0;
      end else if (run_cnt == LIMIT) begin
         held_lvl <= sync_lvl;
         run_cnt  <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign clean_out = held_lvl;

   // A new accepted level always equals the synchronised level it came from
   p_accept_matches_sync_r7: assert property (@(posedge clk) disable iff (rst)
      (held_lvl != $past(held_lvl)) |-> (held_lvl == $past(sync_lvl)));

   // The stability counter never passes its limit
   p_count_bounded_r7: assert property (@(posedge clk) disable iff (rst)
      run_cnt <= LIMIT);

   // An unchanged synchronised level never alters the accepted level
   p_no_spurious_change_r7: assert property (@(posedge clk) disable iff (rst)
      (sync_lvl == held_lvl) |=> $stable(held_lvl));

endmodule

// File: rtl/lc_lamp_latch.sv
module lc_lamp_latch (
   input  logic clk,
   input  logic rst,
   input  logic gate_en,
   input  logic light_req,
   input  logic douse_req,
   output logic lamp_q
);

   always_ff @(posedge clk) begin
      if (rst)            lamp_q <= 1'b0;
      else if (gate_en) begin
         if (douse_req)      lamp_q <= 1'b0;
         else if (light_req) lamp_q <= 1'b1;
      end
   end

   p_light_sets_r1: assert property (@(posedge clk) disable iff (rst)
      (gate_en && light_req && !douse_req) |=> lamp_q);

   p_locked_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !gate_en |=> (lamp_q == $past(lamp_q)));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!light_req && !douse_req) |=> $stable(lamp_q));

   p_douse_wins_r5: assert property (@(posedge clk) disable iff (rst)
      (gate_en && douse_req) |=> !lamp_q);

   p_reset_dark_r6: assert property (@(posedge clk)
      rst |=> !lamp_q);

endmodule

// File: rtl/lc_door_gate.sv
module lc_door_gate #(
   parameter bit          HAS_SENSE   = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic lamp_on,
   input  logic panel_on,
   input  logic sense_raw,
   output logic release_o
);

   logic current_clear;

   generate
      if (HAS_SENSE) begin : g_sense
         logic [SYNC_STAGES-1:0] sense_sh;
         always_ff @(posedge clk) begin
            if (rst) sense_sh <= '0;
            else     sense_sh <= {sense_sh[SYNC_STAGES-2:0], sense_raw};
         end
         assign current_clear = !sense_sh[SYNC_STAGES-1];
      end else begin : g_no_sense
         logic unused_sense;
         assign unused_sense  = sense_raw;
         assign current_clear = 1'b1;
      end
   endgenerate

   assign release_o = !lamp_on && !panel_on && current_clear;

   p_release_needs_safe_r3: assert property (@(posedge clk) disable iff (rst)
      release_o |-> (!lamp_on && !panel_on));

   p_release_needs_dark_r8: assert property (@(posedge clk) disable iff (rst)
      release_o |-> current_clear);

endmodule

// File: rtl/lamp_lockout_ctrl.sv
module lamp_lockout_ctrl
   import lamp_ctrl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned STABLE_CYCLES = 1000,
   parameter bit          HAS_SENSE     = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic on_btn,
   input  logic off_btn,
   input  logic panel_enable,
   input  logic lamp_sense,
   output logic lamp_drive,
   output logic door_release
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("lamp_lockout_ctrl: SYNC_STAGES below 2");
      end
      if (STABLE_CYCLES < 1) begin : g_chk_stable
         $error("lamp_lockout_ctrl: STABLE_CYCLES below 1");
      end
   endgenerate

   ctrl_levels_t raw_lvls;
   ctrl_levels_t clean_lvls;
   logic [NUM_CTRL_CH-1:0] raw_vec;
   logic [NUM_CTRL_CH-1:0] clean_vec;

   assign raw_lvls = '{panel: panel_enable, douse: off_btn, light: on_btn};
   assign raw_vec  = raw_lvls;

   generate
      for (genvar ch = 0; ch < NUM_CTRL_CH; ch++) begin : g_filt
         lc_input_filter #(
            .SYNC_STAGES  (SYNC_STAGES),
            .STABLE_CYCLES(STABLE_CYCLES)
         ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (raw_vec[ch]),
            .clean_out(clean_vec[ch])
         );
      end
   endgenerate

   assign clean_lvls = clean_vec;

   lc_lamp_latch u_latch (
      .clk      (clk),
      .rst      (rst),
      .gate_en  (clean_lvls.panel),
      .light_req(clean_lvls.light),
      .douse_req(clean_lvls.douse),
      .lamp_q   (lamp_drive)
   );

   lc_door_gate #(
      .HAS_SENSE  (HAS_SENSE),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_door (
      .clk      (clk),
      .rst      (rst),
      .lamp_on  (lamp_drive),
      .panel_on (clean_lvls.panel),
      .sense_raw(lamp_sense),
      .release_o(door_release)
   );

   p_door_never_lit_r9: assert property (@(posedge clk) disable iff (rst)
      door_release |-> !lamp_drive);

   p_locked_lamp_steady_r2: assert property (@(posedge clk) disable iff (rst)
      !clean_lvls.panel |=> $stable(lamp_drive));

endmodule

// File: tb/test_lamp_lockout_ctrl.sv
module test_lamp_lockout_ctrl;

   localparam int DEB = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1;
   logic on_btn = 1'b0, off_btn = 1'b0, panel_enable = 1'b0, lamp_sense = 1'b0;
   wire  lamp_drive, door_release;

   lamp_lockout_ctrl #(
      .SYNC_STAGES  (2),
      .STABLE_CYCLES(DEB),
      .HAS_SENSE    (1'b1)
   ) i_lamp_lockout_ctrl (
      .clk         (clk),
      .rst         (rst),
      .on_btn      (on_btn),
      .off_btn     (off_btn),
      .panel_enable(panel_enable),
      .lamp_sense  (lamp_sense),
      .lamp_drive  (lamp_drive),
      .door_release(door_release)
   );

   int    vectors = 0;
   int    miscompares = 0;
   string cur_req = "R6";
   bit    done = 1'b0;

   // Behavioural reference: pin-to-sample delay queues plus stable-run counters
   bit q_on[$], q_off[$], q_en[$], q_sns[$];
   int c_on, c_off, c_en;
   bit d_on, d_off, d_en, m_lamp, m_sns;

   function automatic void settle(input bit v, ref bit d, ref int c);
      if (v == d) c = 0;
      else begin
         c++;
         if (c >= DEB) begin d = v; c = 0; end
      end
   endfunction

   always @(posedge clk) begin
      bit v_on, v_off, v_en;
      if (rst) begin
         q_on = '{0, 0}; q_off = '{0, 0}; q_en = '{0, 0}; q_sns = '{0, 0};
         c_on = 0; c_off = 0; c_en = 0;
         d_on = 0; d_off = 0; d_en = 0; m_lamp = 0; m_sns = 0;
      end else begin
         v_on  = q_on.pop_front();  q_on.push_back(on_btn);
         v_off = q_off.pop_front(); q_off.push_back(off_btn);
         v_en  = q_en.pop_front();  q_en.push_back(panel_enable);
         void'(q_sns.pop_front());  q_sns.push_back(lamp_sense);
         if (d_en) begin
            if (d_off)     m_lamp = 1'b0;
            else if (d_on) m_lamp = 1'b1;
         end
         settle(v_on, d_on, c_on);
         settle(v_off, d_off, c_off);
         settle(v_en, d_en, c_en);
         m_sns = q_sns[0];
      end
   end

   always @(negedge clk) begin
      bit exp_door;
      if (!done) begin
         exp_door = !m_lamp && !d_en && !m_sns;
         vectors++;
         if (lamp_drive !== m_lamp || door_release !== exp_door) begin
            miscompares++;
            $display("FAIL %s model: lamp_drive=%0b door_release=%0b expected %0b/%0b at %0t",
                     cur_req, lamp_drive, door_release, m_lamp, exp_door, $time);
         end
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input bit lamp, input bit door, input string tag);
      #1;
      vectors++;
      if (lamp_drive !== lamp || door_release !== door) begin
         miscompares++;
         $display("FAIL %s: lamp_drive=%0b door_release=%0b expected %0b/%0b",
                  tag, lamp_drive, door_release, lamp, door);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         miscompares++;
         $display("FAIL R6 watchdog: run incomplete, expected completion");
         finish_run();
      end
   end

   initial begin
      bit [15:0] lfsr;
      hold(4);
      rst = 1'b0;
      hold(1);
      expect_out(1'b0, 1'b1, "R6");

      cur_req = "R1";
      panel_enable = 1'b1;
      hold(DEB + 4);
      expect_out(1'b0, 1'b0, "R3");
      on_btn = 1'b1;
      hold(DEB + 2);
      expect_out(1'b0, 1'b0, "R7");
      hold(1);
      expect_out(1'b1, 1'b0, "R1");
      on_btn = 1'b0;

      cur_req = "R4";
      hold(40);
      expect_out(1'b1, 1'b0, "R4");

      cur_req = "R7";
      off_btn = 1'b1;
      hold(DEB - 1);
      off_btn = 1'b0;
      hold(10);
      expect_out(1'b1, 1'b0, "R7");

      cur_req = "R5";
      on_btn = 1'b1; off_btn = 1'b1;
      hold(DEB + 3);
      expect_out(1'b0, 1'b0, "R5");
      hold(5);
      expect_out(1'b0, 1'b0, "R5");
      on_btn = 1'b0; off_btn = 1'b0;
      hold(8);

      cur_req = "R2";
      on_btn = 1'b1; hold(8); on_btn = 1'b0; hold(8);
      panel_enable = 1'b0;
      hold(8);
      off_btn = 1'b1;
      hold(12);
      expect_out(1'b1, 1'b0, "R2");
      off_btn = 1'b0;
      hold(6);

      cur_req = "R3";
      panel_enable = 1'b1;
      hold(8);
      off_btn = 1'b1;
      hold(8);
      expect_out(1'b0, 1'b0, "R3");
      off_btn = 1'b0;
      panel_enable = 1'b0;
      hold(8);
      expect_out(1'b0, 1'b1, "R3");

      cur_req = "R2";
      on_btn = 1'b1;
      hold(12);
      expect_out(1'b0, 1'b1, "R2");
      on_btn = 1'b0;
      hold(4);

      cur_req = "R8";
      lamp_sense = 1'b1;
      hold(2);
      expect_out(1'b0, 1'b0, "R8");
      lamp_sense = 1'b0;
      hold(2);
      expect_out(1'b0, 1'b1, "R8");

      cur_req = "R9";
      panel_enable = 1'b1;
      hold(2);
      expect_out(1'b0, 1'b1, "R9");
      hold(6);
      on_btn = 1'b1;
      hold(8);
      expect_out(1'b1, 1'b0, "R9");
      on_btn = 1'b0;
      hold(4);

      cur_req = "R7";
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         on_btn       = lfsr[0] & lfsr[3];
         off_btn      = lfsr[5] & lfsr[7] & lfsr[1];
         panel_enable = ~(lfsr[9] & lfsr[11] & lfsr[2]);
         lamp_sense   = lfsr[4] & lfsr[6];
         hold(1);
      end
      on_btn = 1'b0; off_btn = 1'b0; lamp_sense = 1'b0; panel_enable = 1'b1;
      hold(10);

      cur_req = "R6";
      on_btn = 1'b1; hold(8); on_btn = 1'b0; hold(2);
      expect_out(1'b1, 1'b0, "R1");
      panel_enable = 1'b0;
      rst = 1'b1;
      hold(2);
      expect_out(1'b0, 1'b1, "R6");
      rst = 1'b0;
      hold(10);
      expect_out(1'b0, 1'b1, "R6");

      finish_run();
   end

endmodule